// File: doc/BRIEF.md
# One-Wire Slave ROM Command Layer

This block is the network-layer front end of a one-wire slave device. It sits between a bit-level slot engine and a memory-function layer. The slot engine reports three events: a completed reset/presence exchange, a bit written by the master, and the start of a read slot. This block uses those events to decode the ROM command that follows each bus reset, and drives a pull-low request for every read slot. When device selection succeeds it gives the memory layer a one-cycle select strobe.

The block holds a 64-bit identity word. Bits 0 to 7 hold an 8-bit family byte, bits 8 to 55 hold a 48-bit serial number, and bits 56 to 63 hold a CRC byte. Hardware computes the CRC from the first 56 bits. The family byte and the serial number are parameters. Four commands are decoded: read identity, match identity, skip identity and search. Any other code, a failed match and a lost search all leave the block silent until the next bus reset.

Top module: `romCmdLayer`

## Requirements
- R1: After the chip reset (`rstN` low), `txLow` and `memSel` are 0, and write or read slots have no effect until the first `busReset` pulse. No selection occurs and every read slot sees `txLow` = 0.
- R2: The identity word holds the family byte (default 8'h14) in bits 0-7, the serial number in bits 8-55 and the CRC byte in bits 56-63. It is sent bit 0 first.
- R3: The CRC byte is the CRC of identity bits 0-55 fed bit 0 first, with polynomial x^8+x^5+x^4+1 in reflected form and an initial value of 0.
- R4: Read identity (code 8'h33): 64 read slots return identity bits 0..63 in order. A slot's bit is 0 exactly when `txLow` = 1 at the start of that slot. `memSel` pulses in the cycle after the 64th slot.
- R5: Skip identity (code 8'hCC): `memSel` pulses in the cycle after the 8th command bit.
- R6: Match identity (code 8'h55): when the 64 written bits equal identity bits 0..63, `memSel` pulses after the 64th bit. At the first differing bit the block goes silent: there is no `memSel` and `txLow` stays 0 until the next `busReset`.
- R7: Search (code 8'hF0): for each identity bit i, the first read slot returns bit i, the second returns its complement, and then a write slot takes the master's bit. When the master's bit equals bit i the block moves to bit i+1. After bit 63, `memSel` pulses.
- R8: During search, a master bit that differs from identity bit i silences the block until the next `busReset`. Later read slots then see `txLow` = 0.
- R9: Any command code other than the four above silences the block until the next `busReset`.
- R10: The command byte is taken from the first 8 write slots after `busReset`, least significant bit first.
- R11: A `busReset` in the same cycle as a write or read slot wins. The slot is discarded and the next write slot is command bit 0.
- R12: After selection the block ignores slots until `busReset`: `txLow` stays 0 and `memSel` does not pulse again.
- R13: `memSel` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReset | input | 1 | One-cycle pulse: a reset pulse was answered with presence |
| wrValid | input | 1 | One-cycle pulse: the master wrote a bit |
| wrBit | input | 1 | Value of the bit written by the master |
| rdReq | input | 1 | One-cycle pulse: a read slot starts; `txLow` is taken in this cycle |
| txLow | output | 1 | 1 = hold the line low in the current read slot (send 0) |
| memSel | output | 1 | One-cycle strobe to the memory-function layer on selection |

## Verification
A bus reset and a slot event can fall in the same cycle. Only one of them may act on the state and the bit index. The bench raises `busReset` together with `wrValid` partway through a command byte, and again in the middle of a read of the identity. A command byte is then sent. A bit taken from the colliding slot would shift that byte by one position, and the code 8'hCC would no longer decode as skip. The collision is judged correct only if the byte selects the device cleanly.

// File: rtl/romCmdPkg.sv
package romCmdPkg;

  localparam int FAM_W    = 8;
  localparam int SERIAL_W = 48;
  localparam int CRC_W    = 8;
  localparam int BODY_W   = FAM_W + SERIAL_W;
  localparam int ID_W     = BODY_W + CRC_W;
  localparam int IDX_W    = $clog2(ID_W);
  localparam int CMD_W    = 8;

  localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH,
    ST_SRCH_T, ST_SRCH_C, ST_SRCH_W, ST_PASS, ST_MUTE
  } romState_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic shiftCmd;
  } dpStrobe_t;

  // Reflected CRC-8 (x^8+x^5+x^4+1), fed bit 0 first, initial value 0.
  function automatic logic [CRC_W-1:0] crcOf(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb = c[0] ^ body[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/romIdPath.sv
module romIdPath
  import romCmdPkg::*;
#(
  parameter logic [FAM_W-1:0]    FAMILY = 8'h14,
  parameter logic [SERIAL_W-1:0] SERIAL = 48'hA1B2C3D4E5F6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             wrBit,
  output logic             idBit,
  output logic [CMD_W-1:0] cmdByte,
  output logic             idxLast,
  output logic             cmdLast
);

  localparam logic [BODY_W-1:0] BODY   = {SERIAL, FAMILY};
  localparam logic [CRC_W-1:0]  CRC    = crcOf(BODY);
  localparam logic [ID_W-1:0]   IDWORD = {CRC, BODY};

  logic [IDX_W-1:0] idx;
  logic [CMD_W-2:0] cmdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (stb.clrIdx) begin
      idx <= '0;
    end else if (stb.incIdx) begin
      idx <= idx + 1'b1;
    end
  end

  // Command bits arrive LSB first; shift in at the top.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (stb.shiftCmd) begin
      cmdReg <= {wrBit, cmdReg[CMD_W-2:1]};
    end
  end

  assign cmdByte = {wrBit, cmdReg};
  assign idBit   = IDWORD[idx];
  assign idxLast = (idx == IDX_W'(ID_W - 1));
  assign cmdLast = (idx == IDX_W'(CMD_W - 1));

  // R10: command bits are counted within one byte
  a_r10_cmd_idx_small: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftCmd && stb.incIdx) |-> (idx < IDX_W'(CMD_W - 1)));

  // R4: an increment moves the index forward by exactly one
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incIdx && !stb.clrIdx) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/romCmdCtl.sv
module romCmdCtl
  import romCmdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             wrValid,
  input  logic             wrBit,
  input  logic             rdReq,
  input  logic             idBit,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             idxLast,
  input  logic             cmdLast,
  output dpStrobe_t        stb,
  output logic             txLow,
  output logic             memSel
);

  romState_t state, nextState;
  logic      selSet;

  always_comb begin
    nextState = state;
    stb       = '0;
    selSet    = 1'b0;
    if (busReset) begin
      nextState  = ST_CMD;
      stb.clrIdx = 1'b1;
    end else begin
      unique case (state)
        ST_CMD: if (wrValid) begin
          stb.shiftCmd = 1'b1;
          if (cmdLast) begin
            stb.clrIdx = 1'b1;
            if (cmdByte == CMD_READ)        nextState = ST_READ;
            else if (cmdByte == CMD_MATCH)  nextState = ST_MATCH;
            else if (cmdByte == CMD_SEARCH) nextState = ST_SRCH_T;
            else if (cmdByte == CMD_SKIP) begin
              nextState = ST_PASS;
              selSet    = 1'b1;
            end else                        nextState = ST_MUTE;
          end else begin
            stb.incIdx = 1'b1;
          end
        end
        ST_READ: if (rdReq) begin
          if (idxLast) begin
            nextState = ST_PASS;
            selSet    = 1'b1;
          end else begin
            stb.incIdx = 1'b1;
          end
        end
        ST_MATCH: if (wrValid) begin
          if (wrBit != idBit) begin
            nextState = ST_MUTE;
          end else if (idxLast) begin
            nextState = ST_PASS;
            selSet    = 1'b1;
          end else begin
            stb.incIdx = 1'b1;
          end
        end
        ST_SRCH_T: if (rdReq) nextState = ST_SRCH_C;
        ST_SRCH_C: if (rdReq) nextState = ST_SRCH_W;
        ST_SRCH_W: if (wrValid) begin
          if (wrBit != idBit) begin
            nextState = ST_MUTE;
          end else if (idxLast) begin
            nextState = ST_PASS;
            selSet    = 1'b1;
          end else begin
            stb.incIdx = 1'b1;
            nextState  = ST_SRCH_T;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      memSel <= 1'b0;
    end else begin
      state  <= nextState;
      memSel <= selSet;
    end
  end

  always_comb begin
    unique case (state)
      ST_READ, ST_SRCH_T: txLow = !idBit;
      ST_SRCH_C:          txLow = idBit;
      default:            txLow = 1'b0;
    endcase
  end

  a_r13_sel_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    memSel |=> !memSel);

  a_r11_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == ST_CMD) && !memSel);

  a_r6_match_mute: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MATCH && wrValid && !busReset && wrBit != idBit) |=> (state == ST_MUTE));

  a_r7_search_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SRCH_C && rdReq && !busReset) |=> (state == ST_SRCH_W));

  a_r12_pass_no_sel: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS && !busReset) |=> !memSel);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !memSel);

endmodule

// File: rtl/romCmdLayer.sv
module romCmdLayer
  import romCmdPkg::*;
#(
  parameter logic [FAM_W-1:0]    FAMILY = 8'h14,
  parameter logic [SERIAL_W-1:0] SERIAL = 48'hA1B2C3D4E5F6
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic wrValid,
  input  logic wrBit,
  input  logic rdReq,
  output logic txLow,
  output logic memSel
);

  dpStrobe_t        stb;
  logic             idBit;
  logic [CMD_W-1:0] cmdByte;
  logic             idxLast;
  logic             cmdLast;

  romIdPath #(.FAMILY(FAMILY), .SERIAL(SERIAL)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBit(wrBit),
    .idBit(idBit), .cmdByte(cmdByte), .idxLast(idxLast), .cmdLast(cmdLast)
  );

  romCmdCtl uCtl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrValid(wrValid),
    .wrBit(wrBit), .rdReq(rdReq), .idBit(idBit), .cmdByte(cmdByte),
    .idxLast(idxLast), .cmdLast(cmdLast), .stb(stb), .txLow(txLow),
    .memSel(memSel)
  );

endmodule

// File: tb/romCmdLayer_test.sv
module romCmdLayer_test;

  localparam logic [7:0]  FAM = 8'h14;
  localparam logic [47:0] SER = 48'hA1B2C3D4E5F6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0;
  logic wrValid = 1'b0;
  logic wrBit = 1'b0;
  logic rdReq = 1'b0;
  logic txLow, memSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] expId;

  always #4 clk = ~clk;

  romCmdLayer #(.FAMILY(FAM), .SERIAL(SER)) uut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrValid(wrValid),
    .wrBit(wrBit), .rdReq(rdReq), .txLow(txLow), .memSel(memSel)
  );

  // kind: 0 silent, 1 skip, 2 read, 3 match, 4 search
  localparam int NV = 7;
  localparam logic [7:0] VCMD  [NV] = '{8'h33, 8'hCC, 8'h55, 8'hF0, 8'h00, 8'hFF, 8'h3C};
  localparam int         VKIND [NV] = '{2, 1, 3, 4, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] benchCrc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    logic fb;
    for (int i = 0; i < 56; i++) begin
      fb = d[i] ^ r[0];
      r  = {fb, r[7:1]} ^ {4'b0000, fb, fb, 2'b00};
    end
    return r;
  endfunction

  task automatic pulseReset();
    busReset = 1'b1; @(negedge clk); busReset = 1'b0;
  endtask

  task automatic writeBit(input logic b);
    wrValid = 1'b1; wrBit = b; @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic readBit(output logic b);
    b = !txLow;
    rdReq = 1'b1; @(negedge clk); rdReq = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) writeBit(c[i]);
  endtask

  // 8 reads that must all be released, and no select
  task automatic checkSilent(input string req);
    logic b;
    logic [7:0] got;
    bit anySel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      readBit(b); got[i] = b;
      if (memSel) anySel = 1'b1;
    end
    chk(got == 8'hFF && !anySel, req, {55'd0, anySel, got}, 64'hFF);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic b, t, c;
    logic [63:0] got;
    bit early;
    expId = {benchCrc({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(txLow == 1'b0 && memSel == 1'b0, "R1 reset outputs", {62'd0, txLow, memSel}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: slots before the first bus reset do nothing
    sendCmd(8'hCC);
    chk(memSel == 1'b0, "R1 skip ignored before busReset", memSel, 0);
    checkSilent("R1 reads before busReset");

    for (int v = 0; v < NV; v++) begin
      pulseReset();
      sendCmd(VCMD[v]);
      case (VKIND[v])
        1: begin // R5, R10
          chk(memSel == 1'b1, "R5 skip select", memSel, 1);
          @(negedge clk);
          chk(memSel == 1'b0, "R13 skip strobe width", memSel, 0);
        end
        2: begin // R4, R2, R3
          early = 1'b0;
          for (int i = 0; i < 64; i++) begin
            readBit(b); got[i] = b;
            if (i < 63 && memSel) early = 1'b1;
          end
          chk(got[7:0] == 8'h14, "R2 family byte", got[7:0], 8'h14);
          chk(got[55:8] == SER, "R2 serial field", got[55:8], SER);
          chk(got[63:56] == expId[63:56], "R3 crc byte", got[63:56], expId[63:56]);
          chk(got == expId, "R4 read identity", got, expId);
          chk(memSel == 1'b1 && !early, "R4 select after 64th slot", {early, memSel}, 1);
          @(negedge clk);
          chk(memSel == 1'b0, "R13 read strobe width", memSel, 0);
          checkSilent("R12 ignore after read select");
        end
        3: begin // R6
          early = 1'b0;
          for (int i = 0; i < 64; i++) begin
            writeBit(expId[i]);
            if (i < 63 && memSel) early = 1'b1;
          end
          chk(memSel == 1'b1 && !early, "R6 match select", {early, memSel}, 1);
          @(negedge clk);
          chk(memSel == 1'b0, "R13 match strobe width", memSel, 0);
        end
        4: begin // R7
          early = 1'b0;
          for (int i = 0; i < 64; i++) begin
            readBit(t); readBit(c);
            if (t !== expId[i] || c !== !expId[i]) early = 1'b1;
            writeBit(expId[i]);
            if (i < 63 && memSel) early = 1'b1;
          end
          chk(!early, "R7 search bit pairs", early, 0);
          chk(memSel == 1'b1, "R7 search select", memSel, 1);
          @(negedge clk);
          chk(memSel == 1'b0, "R13 search strobe width", memSel, 0);
        end
        default: begin // R9
          checkSilent("R9 unknown command silent");
          sendCmd(8'hCC);
          chk(memSel == 1'b0, "R9 later command ignored", memSel, 0);
        end
      endcase
    end

    // R6: mismatch at bit 10
    pulseReset(); sendCmd(8'h55);
    early = 1'b0;
    for (int i = 0; i < 64; i++) begin
      writeBit(i == 10 ? !expId[i] : expId[i]);
      if (memSel) early = 1'b1;
    end
    @(negedge clk);
    chk(!early && memSel == 1'b0, "R6 match mismatch no select", early, 0);
    checkSilent("R6 silent after mismatch");

    // R8: search loses at bit 5
    pulseReset(); sendCmd(8'hF0);
    for (int i = 0; i < 5; i++) begin
      readBit(t); readBit(c); writeBit(expId[i]);
    end
    readBit(t); readBit(c);
    chk(t == expId[5] && c == !expId[5], "R7 search bit 5 pair", {t, c}, {expId[5], !expId[5]});
    writeBit(!expId[5]);
    checkSilent("R8 silent after search loss");

    // R12: after skip, a read command is ignored
    pulseReset(); sendCmd(8'hCC);
    @(negedge clk);
    sendCmd(8'h33);
    chk(memSel == 1'b0, "R12 no reselect", memSel, 0);
    checkSilent("R12 ignore after skip");

    // R11: bus reset collides with a write slot mid-command
    pulseReset();
    for (int i = 0; i < 4; i++) writeBit(1'b1);
    busReset = 1'b1; wrValid = 1'b1; wrBit = 1'b1;
    @(negedge clk);
    busReset = 1'b0; wrValid = 1'b0;
    sendCmd(8'hCC);
    chk(memSel == 1'b1, "R11 reset wins over write slot", memSel, 1);

    // R11: bus reset collides with a read slot mid identity read
    pulseReset(); sendCmd(8'h33);
    for (int i = 0; i < 20; i++) readBit(b);
    busReset = 1'b1; rdReq = 1'b1;
    @(negedge clk);
    busReset = 1'b0; rdReq = 1'b0;
    sendCmd(8'hCC);
    chk(memSel == 1'b1, "R11 reset wins over read slot", memSel, 1);

    // R10: a command sent MSB first (0x33 reversed is 0xCC) reads as read identity
    pulseReset(); sendCmd(8'h33);
    chk(memSel == 1'b0, "R10 LSB-first decode", memSel, 0);
    readBit(b);
    chk(b == expId[0], "R10 read started", b, expId[0]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule